// File: doc/BRIEF.md
# Three-Address I2C Target with Port-Group Select

This block is the serial-bus front end of a twelve-port power controller. It listens on SCL and on a separate SDA input, and it drives a separate open-drain SDA output. With the two SDA pins wired apart, the bus can pass through isolators. With them tied together, they act as one ordinary bidirectional SDA line. The target answers at three consecutive 7-bit addresses. Each address picks one group of four ports. The group index is handed to the register file together with the register pointer and the write data.

The 7-bit base address is taken from five strap inputs with two fixed bits: `{strap_hi, 1, 0, strap_lo[3:0]}`. The base address selects group 0 (ports 1–4), base+1 selects group 1 (ports 5–8) and base+2 selects group 2 (ports 9–12). On the board, the straps are pulled up when left open.

A write transaction works as follows. The first data byte after the address loads the register pointer. Each later byte produces a one-cycle write strobe and then advances the pointer. Reads shift out the register file's data for the current pointer, most significant bit first, and advance the pointer on every byte. A flag marks the span from START to STOP so that other logic can defer its updates.

Top module: `i2c_group_target`

## Requirements
- R1: After a START, an address byte whose upper seven bits equal `{strap_hi,1,0,strap_lo}` is acknowledged (SDA driven low during the ninth SCL pulse), and `grp_idx` becomes 0.
- R2: The addresses base+1 and base+2 are acknowledged as well and set `grp_idx` to 1 and 2. `grp_idx` never exceeds 2.
- R3: For any other address, `sda_o` stays high until the next START or STOP. No byte is acknowledged and no write strobe occurs.
- R4: `in_txn` rises after a START (SDA falling while SCL is high) and falls after a STOP (SDA rising while SCL is high). SCL and SDA are each passed through two synchronizing flops before edge detection.
- R5: In a write (address bit 0 = 0), the first data byte loads `reg_addr` and produces no write strobe.
- R6: Each later write byte produces `wr_en` high for exactly one clock while `in_txn` is high, carrying `wr_data` = the byte, `reg_addr` = the pointer and `grp_idx` = the group. The pointer increases by one in the next clock.
- R7: Every data byte of a matched write is acknowledged.
- R8: In a read (address bit 0 = 1), the target shifts out `rd_data` for the current `reg_addr` MSB first. The pointer advances by one as each byte is loaded.
- R9: A controller ACK after a read byte causes the next byte to be sent. A NACK ends the read, and `sda_o` then stays high until START or STOP.
- R10: `sda_o` is high during and after reset, and it is high whenever `in_txn` is low.
- R11: A repeated START restarts address matching without clearing the pointer, so a pointer write followed by a repeated START and a read returns data from that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from bus |
| sda_i | input | 1 | Serial data input (high impedance) |
| sda_o | output | 1 | Serial data output, 0 = pull low, 1 = release |
| strap_hi | input | 1 | Address bit 6 strap |
| strap_lo | input | 4 | Address bits 3..0 strap |
| in_txn | output | 1 | High from START to STOP |
| grp_idx | output | 2 | Selected four-port group (0..2) |
| reg_addr | output | 8 | Register pointer |
| wr_data | output | 8 | Write data byte |
| wr_en | output | 1 | One-cycle write strobe |
| rd_data | input | 8 | Read data for `grp_idx`/`reg_addr` |

## Verification
Two events can meet in the same cycle here. One is the pointer step that follows a write strobe or a read-byte load. The other is a STOP or repeated START that arrives right after the ACK clock of that byte. The bench ends write bursts immediately after the last acknowledge and often follows a pointer write at once with a repeated START and a read. Constrained-random runs mix groups, pointers and burst lengths. The outcome is judged at the ports: the strobe log must show consecutive addresses, and the first byte read back must come from exactly the pointer that was written, so a lost or doubled increment shows up as a data mismatch.

// File: rtl/i2c_group_target.sv
module i2c_group_target #(
  parameter int GROUPS = 3,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_o,
  input  logic          strap_hi,
  input  logic [3:0]    strap_lo,
  output logic          in_txn,
  output logic [GW-1:0] grp_idx,
  output logic [7:0]    reg_addr,
  output logic [7:0]    wr_data,
  output logic          wr_en,
  input  logic [7:0]    rd_data
);
  localparam logic [6:0] NG = 7'(GROUPS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_MACK, S_SKIP} st_t;
  st_t st;

  logic [2:0] scl_p, sda_p;
  logic [7:0] sh, tx;
  logic [3:0] cnt;
  logic       rw, first;

  wire scl_s = scl_p[1];
  wire sda_s = sda_p[1];
  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire start = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];

  wire [6:0] base = {strap_hi, 2'b10, strap_lo};
  wire [6:0] off  = sh[7:1] - base;
  wire       hit  = off < NG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111; sda_p <= 3'b111;
      st <= S_IDLE; sda_o <= 1'b1; in_txn <= 1'b0;
      sh <= '0; tx <= '0; cnt <= '0; rw <= 1'b0; first <= 1'b0;
      grp_idx <= '0; reg_addr <= '0; wr_data <= '0; wr_en <= 1'b0;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
      wr_en <= 1'b0;
      if (wr_en) reg_addr <= reg_addr + 8'd1;
      if (start) begin
        st <= S_ADDR; cnt <= '0; sda_o <= 1'b1; in_txn <= 1'b1;
      end else if (stop) begin
        st <= S_IDLE; sda_o <= 1'b1; in_txn <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WR: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (hit) begin
                  grp_idx <= off[GW-1:0]; rw <= sh[0]; sda_o <= 1'b0; st <= S_AACK;
                end else st <= S_SKIP;
              end else begin
                sda_o <= 1'b0; st <= S_WACK;
                if (first) begin reg_addr <= sh; first <= 1'b0; end
                else begin wr_data <= sh; wr_en <= 1'b1; end
              end
            end
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx <= rd_data; sda_o <= rd_data[7]; reg_addr <= reg_addr + 8'd1; st <= S_RD;
            end else begin
              sda_o <= 1'b1; first <= 1'b1; st <= S_WR;
            end
          end
          S_WACK: if (scl_fall) begin sda_o <= 1'b1; st <= S_WR; end
          S_RD: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_o <= 1'b1; cnt <= '0; st <= S_MACK;
              end else begin
                sda_o <= tx[6]; tx <= {tx[6:0], 1'b0};
              end
            end
          end
          S_MACK: if (scl_rise) st <= sda_s ? S_SKIP : S_AACK;
          default: ;
        endcase
      end
    end
  end

  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: rtl/i2c_group_target_chk.sv
module i2c_group_target_chk #(
  parameter int GROUPS = 3,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_o,
  input logic          in_txn,
  input logic          wr_en,
  input logic [7:0]    reg_addr,
  input logic [GW-1:0] grp_idx
);
  localparam logic [GW:0] NG = (GW+1)'(GROUPS);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !in_txn |-> sda_o); // R10
  AST_STROBE_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> in_txn); // R6
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> reg_addr == $past(reg_addr) + 8'd1); // R6
  AST_GRP_RANGE: assert property (@(posedge clk) disable iff (!rst_n) {1'b0, grp_idx} < NG); // R2
endmodule

bind i2c_group_target i2c_group_target_chk #(.GROUPS(GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_o(sda_o), .in_txn(in_txn),
  .wr_en(wr_en), .reg_addr(reg_addr), .grp_idx(grp_idx)
);

// File: tb/tb_i2c_group_target.sv
`timescale 1ns/1ps
module tb_i2c_group_target;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic strap_hi = 1'b1;
  logic [3:0] strap_lo = 4'hF;
  logic sda_o, in_txn, wr_en;
  logic [1:0] grp_idx;
  logic [7:0] reg_addr, wr_data, rd_data;
  wire sda_bus = sda_m & sda_o;

  int nchk = 0, nerr = 0, wcnt = 0;
  logic [17:0] wlog [0:255];

  always #5 clk = ~clk;

  function automatic logic [7:0] exp_rd(input logic [1:0] g, input logic [7:0] a);
    return (a * 8'd7) ^ {g, 6'h15};
  endfunction

  assign rd_data = exp_rd(grp_idx, reg_addr);

  i2c_group_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_o(sda_o),
    .strap_hi(strap_hi), .strap_lo(strap_lo), .in_txn(in_txn), .grp_idx(grp_idx),
    .reg_addr(reg_addr), .wr_data(wr_data), .wr_en(wr_en), .rd_data(rd_data)
  );

  always @(negedge clk) if (wr_en && wcnt < 256) begin
    wlog[wcnt] = {grp_idx, reg_addr, wr_data};
    wcnt = wcnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
  endtask

  task automatic bitx(input logic b);
    sda_m = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) bitx(b[i]);
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); ack = !sda_bus; qw(); scl = 1'b0; qw();
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qw(); scl = 1'b1; qw(); d = {d[6:0], sda_bus}; qw(); scl = 1'b0; qw();
    end
    bitx(!mack);
  endtask

  function automatic logic [6:0] base_addr();
    return {strap_hi, 2'b10, strap_lo};
  endfunction

  task automatic do_write(input logic [1:0] g, input logic [7:0] ptr, input int n);
    bit ack;
    int w0;
    logic [7:0] dat [0:7];
    string rq;
    rq = (g == 0) ? "R1" : "R2";
    w0 = wcnt;
    i2c_start();
    chk(in_txn == 1'b1, "R4 in_txn after START", in_txn, 1);
    wbyte({7'(base_addr() + 7'(g)), 1'b0}, ack);
    chk(ack, rq, ack, 1);
    chk(grp_idx == g, rq, grp_idx, g);
    wbyte(ptr, ack);
    chk(ack, "R7 pointer ack", ack, 1);
    chk(wcnt == w0, "R5 no strobe on pointer", wcnt - w0, 0);
    chk(reg_addr == ptr, "R5 pointer load", reg_addr, ptr);
    for (int i = 0; i < n; i++) begin
      dat[i] = 8'($urandom);
      wbyte(dat[i], ack);
      chk(ack, "R7 data ack", ack, 1);
    end
    i2c_stop();
    repeat (4) @(negedge clk);
    chk(in_txn == 1'b0, "R4 in_txn after STOP", in_txn, 0);
    chk(wcnt == w0 + n, "R6 strobe count", wcnt - w0, n);
    for (int i = 0; i < n; i++)
      chk(wlog[w0+i] == {g, 8'(ptr + 8'(i)), dat[i]}, "R6 strobe content", wlog[w0+i], {g, 8'(ptr + 8'(i)), dat[i]});
  endtask

  task automatic do_read(input logic [1:0] g, input logic [7:0] ptr, input int n);
    bit ack;
    logic [7:0] d;
    i2c_start();
    wbyte({7'(base_addr() + 7'(g)), 1'b0}, ack);
    chk(ack, "R2 write address ack", ack, 1);
    wbyte(ptr, ack);
    chk(ack, "R7 pointer ack", ack, 1);
    i2c_start();
    chk(in_txn == 1'b1, "R11 in_txn across repeated START", in_txn, 1);
    wbyte({7'(base_addr() + 7'(g)), 1'b1}, ack);
    chk(ack, "R11 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i < n - 1, d);
      chk(d == exp_rd(g, 8'(ptr + 8'(i))), "R8 read data", d, exp_rd(g, 8'(ptr + 8'(i))));
    end
    rbyte(1'b0, d);
    chk(d == 8'hFF, "R9 released after NACK", d, 8'hFF);
    i2c_stop();
    repeat (4) @(negedge clk);
    chk(sda_o == 1'b1, "R10 sda_o idle", sda_o, 1);
  endtask

  task automatic do_miss();
    bit ack;
    int w0;
    logic [6:0] a;
    w0 = wcnt;
    a = ($urandom % 2) ? 7'(base_addr() + 7'd3) : 7'(base_addr() - 7'd1);
    i2c_start();
    wbyte({a, 1'($urandom)}, ack);
    chk(!ack, "R3 foreign address", ack, 0);
    wbyte(8'($urandom), ack);
    chk(!ack, "R3 byte after foreign address", ack, 0);
    wbyte(8'($urandom), ack);
    chk(!ack, "R3 second byte", ack, 0);
    chk(sda_o == 1'b1, "R3 sda_o released", sda_o, 1);
    i2c_stop();
    chk(wcnt == w0, "R3 no strobe", wcnt - w0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(sda_o == 1'b1, "R10 reset sda_o", sda_o, 1);
    chk(in_txn == 1'b0, "R4 reset in_txn", in_txn, 0);
    chk(wr_en == 1'b0, "R6 reset wr_en", wr_en, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // straps all high: highest base, base+2 = 7'b1110001
    do_write(2'd0, 8'hFE, 3);
    do_write(2'd2, 8'hFF, 2);
    do_read(2'd1, 8'h10, 3);
    do_miss();
    strap_hi = 1'($urandom);
    strap_lo = 4'($urandom);
    repeat (4) @(negedge clk);
    for (int g = 0; g < 3; g++) do_write(2'(g), 8'($urandom), 1 + int'($urandom % 4));
    for (int g = 0; g < 3; g++) do_read(2'(g), 8'($urandom), 1 + int'($urandom % 3));
    do_miss();
    for (int k = 0; k < 16; k++) begin
      int g;
      g = int'($urandom % 3);
      case ($urandom % 3)
        0: do_write(2'(g), 8'($urandom), 1 + int'($urandom % 4));
        1: do_read(2'(g), 8'($urandom), 1 + int'($urandom % 4));
        default: do_miss();
      endcase
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule